// File: doc/BRIEF.md
# Multi-Track NRZI Tape Write Channel

This block is the digital write path for a parallel tape head with 7 or 9 tracks. The track count is set by a parameter. On each write strobe, every track whose data bit is true accepts a ONE. That ONE starts the track's own deskew countdown, which is measured in clock cycles and loaded from a small per-track delay register. When the countdown runs out, the track's write flip-flop toggles. The flip-flop output stands for the direction of head current, so a ONE is a flux change and a ZERO is the absence of one. Because each track has its own delay, the fixed misalignment between head gaps can be trimmed out track by track.

At the end of a data block, a write reset pulse closes the block with a check character. Every track whose flip-flop is still set receives one more ONE through the same deskew-and-toggle path. After that, every track has seen an even number of ONEs and every flip-flop rests in its reset state, ready for the next block. The flip-flops and all pending countdowns are held clear whenever write permit or run is false.

The block reports two timing faults as one-cycle flags. The first is a strobe that arrives too soon after a write reset, against a configurable minimum gap. The second is a ONE aimed at a track whose countdown is still running; that ONE is dropped, not queued. A per-track toggle pulse is provided for downstream echo checking.

Top module: `nrzi_write_chan`

## Requirements
- R1: A track accepts a ONE only at a clock edge where write permit and run are true, `wr_strobe_i` is 1 and that track's bit of `wr_data_i` is 1. Data without a strobe, or a strobe with the data bit at 0, never toggles the track.
- R2: A ONE accepted at clock edge E with deskew value d toggles that track's `head_o` bit at edge E+d+1. A delay of 0 gives a toggle on the cycle after capture. A ZERO produces no change.
- R3: Each track n has its own deskew register. It is written with `dly_val_i` at a clock edge where `dly_we_i` is 1 and `dly_sel_i` equals n; track index 0 is bit 0 of the vectors. All deskew registers reset to 0. A capture uses the value the register held before that edge.
- R4: A one-cycle `wr_reset_i` pulse feeds one ONE into every track whose `head_o` bit is 1, using that track's deskew. Once those toggles complete, every `head_o` bit is 0.
- R5: Across a block closed by `wr_reset_i`, including the check character, each track's `toggled_o` bit pulses an even number of times.
- R6: While `wr_permit_i` or `run_i` is 0, every `head_o` bit is 0 from the following edge onward. Pending deskew countdowns are discarded and strobes are ignored.
- R7: If `wr_reset_i` is high at edge c, a strobe at edge c+k with 1 <= k <= GAP_CYC raises `gap_err_o` for the one cycle after that edge. A strobe at k = GAP_CYC+1 does not.
- R8: A ONE (from data or from the check character) aimed at a track whose countdown is still running raises `overrun_o` for one cycle. That ONE is discarded, and the pending toggle proceeds unchanged.
- R9: `toggled_o[n]` is high for exactly the cycle in which `head_o[n]` has just changed because of a toggle.
- R10: After `rst_ni` is released, `head_o`, `toggled_o`, `overrun_o` and `gap_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | TRACKS | Per-track write data, 1 = ONE |
| wr_strobe_i | input | 1 | Write strobe, one cycle per character |
| wr_reset_i | input | 1 | End-of-block pulse that writes the check character |
| wr_permit_i | input | 1 | Write permit level |
| run_i | input | 1 | Tape run level |
| dly_we_i | input | 1 | Deskew register write enable |
| dly_sel_i | input | SEL_W | Track index for a deskew write |
| dly_val_i | input | DLY_W | Deskew value in cycles |
| head_o | output | TRACKS | Per-track write flip-flop (head current direction) |
| toggled_o | output | TRACKS | One-cycle pulse per track toggle |
| overrun_o | output | 1 | ONE dropped on a busy track |
| gap_err_o | output | 1 | Strobe inside the post-reset gap |

## Verification
The hardest state to reach from the ports is a check character that lands on a mix of tracks: some still holding a set flip-flop, others clear, each with a different deskew value. Reaching it also requires that no countdown is still pending when the reset arrives. The stimulus writes random deskew values to every track, then sends blocks of random characters with random spacing, some of which overrun. Each block ends with an idle stretch longer than the largest delay, then a reset pulse. Toggle parity and the final flip-flop state are checked per track after every block. Directed cases then pin down the exact toggle cycle, the gap boundary on both sides, and an overrun that is dropped rather than queued.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;
  localparam int unsigned MAX_TRACKS = 9;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_WAIT = 2'd1
  } trk_state_e;
endpackage

// File: rtl/nrzi_deskew_regs.sv
module nrzi_deskew_regs #(
  parameter int unsigned TRACKS = 9,
  parameter int unsigned DLY_W  = 4,
  parameter int unsigned SEL_W  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [DLY_W-1:0]              val_i,
  output logic [TRACKS-1:0][DLY_W-1:0]  dly_o
);
  for (genvar t = 0; t < TRACKS; t++) begin : g_reg
    logic hit;
    assign hit = we_i && (sel_i == SEL_W'(t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  dly_o[t] <= '0;
      else if (hit) dly_o[t] <= val_i;
    end
  end
endmodule

// File: rtl/nrzi_track.sv
module nrzi_track
  import nrzi_pkg::*;
#(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             head_o,
  output logic             toggled_o,
  output logic             busy_o
);
  trk_state_e      state_q;
  logic [DLY_W-1:0] cnt_q;

  assign busy_o = (state_q == TRK_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TRK_IDLE;
      cnt_q     <= '0;
      head_o    <= 1'b0;
      toggled_o <= 1'b0;
    end else if (!en_i) begin
      // direct clear while writing is not allowed
      state_q   <= TRK_IDLE;
      cnt_q     <= '0;
      head_o    <= 1'b0;
      toggled_o <= 1'b0;
    end else begin
      toggled_o <= 1'b0;
      case (state_q)
        TRK_IDLE: begin
          if (start_i) begin
            state_q <= TRK_WAIT;
            cnt_q   <= dly_i;
          end
        end
        TRK_WAIT: begin
          if (cnt_q == '0) begin
            head_o    <= ~head_o;
            toggled_o <= 1'b1;
            state_q   <= TRK_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= TRK_IDLE;
      endcase
    end
  end

  AST_CAPTURE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && !busy_o) |=> busy_o) else $error("capture did not arm"); // R1

  AST_HEAD_ONLY_ON_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_o != $past(head_o)) |-> (toggled_o || !$past(en_i))) else $error("head moved without toggle"); // R9

  AST_TOGGLE_ENDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggled_o |-> !busy_o) else $error("toggle while still waiting"); // R2
endmodule

// File: rtl/nrzi_gap_mon.sv
module nrzi_gap_mon #(
  parameter int unsigned GAP_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_reset_i,
  input  logic strobe_i,
  output logic gap_err_o
);
  localparam int unsigned GAP_W = (GAP_CYC < 1) ? 1 : $clog2(GAP_CYC + 1);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      gap_err_o <= 1'b0;
    end else if (!en_i) begin
      gap_q     <= '0;
      gap_err_o <= 1'b0;
    end else begin
      gap_err_o <= strobe_i && (gap_q != '0);
      if (wr_reset_i)        gap_q <= GAP_W'(GAP_CYC);
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

  if (GAP_CYC > 0) begin : g_ast
    AST_GAP_NEXT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i) && $past(wr_reset_i) && !wr_reset_i && strobe_i) |=> gap_err_o)
      else $error("strobe right after reset not flagged"); // R7
  end
endmodule

// File: rtl/nrzi_write_chan.sv
module nrzi_write_chan
  import nrzi_pkg::*;
#(
  parameter int unsigned TRACKS  = 9,
  parameter int unsigned DLY_W   = 4,
  parameter int unsigned GAP_CYC = 12,
  localparam int unsigned SEL_W  = sel_width(TRACKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRACKS-1:0] wr_data_i,
  input  logic              wr_strobe_i,
  input  logic              wr_reset_i,
  input  logic              wr_permit_i,
  input  logic              run_i,
  input  logic              dly_we_i,
  input  logic [SEL_W-1:0]  dly_sel_i,
  input  logic [DLY_W-1:0]  dly_val_i,
  output logic [TRACKS-1:0] head_o,
  output logic [TRACKS-1:0] toggled_o,
  output logic              overrun_o,
  output logic              gap_err_o
);
  logic                         en;
  logic [TRACKS-1:0]            start;
  logic [TRACKS-1:0]            busy;
  logic [TRACKS-1:0][DLY_W-1:0] dly;

  assign en = wr_permit_i && run_i;

  // data ONEs and check-character ONEs share one path
  assign start = ({TRACKS{wr_strobe_i}} & wr_data_i) | ({TRACKS{wr_reset_i}} & head_o);

  nrzi_deskew_regs #(.TRACKS(TRACKS), .DLY_W(DLY_W), .SEL_W(SEL_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (dly_we_i),
    .sel_i (dly_sel_i),
    .val_i (dly_val_i),
    .dly_o (dly)
  );

  for (genvar t = 0; t < TRACKS; t++) begin : g_trk
    nrzi_track #(.DLY_W(DLY_W)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en),
      .start_i  (start[t]),
      .dly_i    (dly[t]),
      .head_o   (head_o[t]),
      .toggled_o(toggled_o[t]),
      .busy_o   (busy[t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_o <= 1'b0;
    else         overrun_o <= en && |(start & busy);
  end

  nrzi_gap_mon #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .wr_reset_i(wr_reset_i),
    .strobe_i  (wr_strobe_i),
    .gap_err_o (gap_err_o)
  );

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (head_o == '0)) else $error("heads not cleared while disabled"); // R6

  AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && wr_strobe_i && |(wr_data_i & busy)) |=> overrun_o) else $error("overrun missed"); // R8

  AST_NO_TOGGLE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (toggled_o == '0)) else $error("toggle while disabled"); // R6
endmodule

// File: tb/nrzi_write_chan_tb.sv
module nrzi_write_chan_tb;
  localparam int N   = 9;
  localparam int DW  = 4;
  localparam int GAP = 12;
  localparam int SW  = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] data = '0;
  logic strobe = 0, wrst = 0, permit = 0, run = 0, dwe = 0;
  logic [SW-1:0] dsel = '0;
  logic [DW-1:0] dval = '0;
  logic [N-1:0] head_o, toggled_o;
  logic overrun_o, gap_err_o;

  int checks = 0, fails = 0, cyc = 0;
  int togcnt [N];
  bit model_on = 0;

  // reference state
  logic [N-1:0] m_head = '0, m_busy = '0, m_tog = '0;
  int m_cnt [N];
  int m_dly [N];
  logic m_ovr = 0, m_gap = 0;
  int m_gcnt = 0;

  always #4 clk = ~clk;

  nrzi_write_chan #(.TRACKS(N), .DLY_W(DW), .GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(data), .wr_strobe_i(strobe),
    .wr_reset_i(wrst), .wr_permit_i(permit), .run_i(run), .dly_we_i(dwe),
    .dly_sel_i(dsel), .dly_val_i(dval), .head_o(head_o), .toggled_o(toggled_o),
    .overrun_o(overrun_o), .gap_err_o(gap_err_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_head = '0; m_busy = '0; m_tog = '0; m_ovr = 0; m_gap = 0; m_gcnt = 0;
      for (int t = 0; t < N; t++) begin m_cnt[t] = 0; m_dly[t] = 0; end
    end else begin
      if (!(permit && run)) begin
        m_head = '0; m_busy = '0; m_tog = '0; m_ovr = 0; m_gap = 0; m_gcnt = 0;
      end else begin
        logic [N-1:0] st;
        logic ov;
        ov = 0;
        st = ({N{strobe}} & data) | ({N{wrst}} & m_head);
        for (int t = 0; t < N; t++) begin
          m_tog[t] = 0;
          if (st[t] && m_busy[t]) ov = 1;
          if (m_busy[t]) begin
            if (m_cnt[t] == 0) begin
              m_head[t] = ~m_head[t]; m_tog[t] = 1; m_busy[t] = 0;
            end else m_cnt[t]--;
          end else if (st[t]) begin
            m_busy[t] = 1; m_cnt[t] = m_dly[t];
          end
        end
        m_ovr = ov;
        m_gap = strobe && (m_gcnt != 0);
        if (wrst) m_gcnt = GAP;
        else if (m_gcnt != 0) m_gcnt--;
      end
      if (dwe && dsel < N) m_dly[dsel] = dval;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) for (int t = 0; t < N; t++) if (toggled_o[t]) togcnt[t]++;
    if (model_on) begin
      chk(head_o == m_head, "R2", "head vs model", head_o, m_head);
      chk(toggled_o == m_tog, "R9", "toggled vs model", toggled_o, m_tog);
      chk(overrun_o == m_ovr, "R8", "overrun vs model", overrun_o, m_ovr);
      chk(gap_err_o == m_gap, "R7", "gap flag vs model", gap_err_o, m_gap);
    end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) tick(); endtask

  task automatic set_dly(input int t, input int v);
    dwe = 1; dsel = SW'(t); dval = DW'(v); tick(); dwe = 0;
  endtask

  task automatic enable(input bit on);
    permit = on; run = on; tick();
  endtask

  task automatic clear_cnt();
    for (int t = 0; t < N; t++) togcnt[t] = 0;
  endtask

  task automatic strobe_once(input logic [N-1:0] d);
    data = d; strobe = 1; tick(); strobe = 0; data = '0;
  endtask

  task automatic pulse_reset();
    wrst = 1; tick(); wrst = 0;
  endtask

  initial begin
    logic h0;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_n = 1;
    tick();
    chk(head_o == '0 && toggled_o == '0, "R10", "outputs after reset", head_o, 0);
    chk(!overrun_o && !gap_err_o, "R10", "flags after reset", {overrun_o, gap_err_o}, 0);
    model_on = 1;

    // R3/R2: exact toggle cycle for a track with its own delay
    for (int t = 0; t < N; t++) set_dly(t, 0);
    set_dly(2, 3);
    set_dly(5, 7);
    enable(1);
    h0 = head_o[2];
    strobe_once(N'(1) << 2);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(head_o[2] == h0, "R3", "track2 before its delay", head_o[2], h0);
    end
    tick();
    chk(head_o[2] == !h0, "R2", "track2 toggle at delay+1", head_o[2], !h0);
    chk(toggled_o == (N'(1) << 2), "R9", "toggle pulse", toggled_o, N'(1) << 2);
    tick();
    chk(toggled_o == '0, "R9", "pulse is one cycle", toggled_o, 0);
    // delay 0 toggles on the next cycle
    strobe_once(N'(1));
    tick();
    chk(head_o[0] == 1'b1, "R2", "zero delay toggles next cycle", head_o[0], 1);

    // R1: data without strobe, strobe without data
    data = '1; idle(6); data = '0;
    chk(head_o == 9'h005, "R1", "data alone ignored", head_o, 9'h005);
    strobe_once('0); idle(10);
    chk(head_o == 9'h005, "R1", "strobe alone ignored", head_o, 9'h005);

    // R4: check character clears set tracks
    idle(GAP);
    pulse_reset(); idle(10);
    chk(head_o == '0, "R4", "heads cleared by check char", head_o, 0);

    // R7: gap boundary both sides
    idle(GAP + 2);
    pulse_reset(); idle(GAP - 1);
    strobe_once('0);
    chk(gap_err_o == 1'b1, "R7", "strobe at last gap cycle", gap_err_o, 1);
    idle(GAP + 2);
    pulse_reset(); idle(GAP);
    strobe_once('0);
    chk(gap_err_o == 1'b0, "R7", "strobe just after gap", gap_err_o, 0);

    // R8: second ONE on a busy track dropped
    idle(4);
    set_dly(0, 5);
    clear_cnt();
    strobe_once(N'(1));
    tick();
    strobe_once(N'(1));
    chk(overrun_o == 1'b1, "R8", "overrun flagged", overrun_o, 1);
    idle(15);
    chk(togcnt[0] == 1, "R8", "overrun not queued", togcnt[0], 1);

    // R6: disable clears head and pending countdown; strobes ignored
    set_dly(5, 9);
    strobe_once(N'(1) << 5);
    idle(2);
    run = 0; tick();
    chk(head_o == '0, "R6", "disable clears heads", head_o, 0);
    strobe_once('1); idle(2);
    clear_cnt();
    run = 1; idle(15);
    chk(head_o == '0 && togcnt[5] == 0, "R6", "no toggle after disable", head_o, 0);
    enable(0); idle(2);

    // random blocks, each closed by a check character
    for (int b = 0; b < 40; b++) begin
      for (int t = 0; t < N; t++) set_dly(t, $urandom_range(0, (1 << DW) - 1));
      enable(1);
      clear_cnt();
      for (int c = 0; c < 30; c++) begin
        strobe_once(N'($urandom));
        idle($urandom_range(0, 18));
      end
      idle(20);
      pulse_reset();
      idle(20);
      chk(head_o == '0, "R4", "block ends with heads clear", head_o, 0);
      for (int t = 0; t < N; t++)
        chk(togcnt[t] % 2 == 0, "R5", "even toggles per track", togcnt[t], togcnt[t] & ~1);
      enable(0);
      idle(2);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule